// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the chip last went through reset. A reset sequencer outside the block raises a one-cycle capture strobe at the moment of reset entry. On that cycle the block samples every reset source and stores one flag per source in an 8-bit read-only status register. A flag is set if its source is active at that moment and is cleared if it is not. Several flags can therefore be set together.

A power-on event always marks the low-voltage flag as well, because the supply is still below the low-voltage threshold while it ramps. A reset that the debug host forces clears every flag. Firmware reads the register over a simple bus port, but it can never change the flags. A bus write to the register's address is treated only as a watchdog service: it produces a one-cycle watchdog-clear pulse and leaves the stored flags as they were.

The block's own `rst_n` clears the register once at start-up. After that, only capture strobes change the register.

Top module: `rst_cause_latch`

## Requirements
- R1: While `rst_n` is low, the register reads 0x00 and `wdog_clr_o` is low.
- R2: On a clock edge where `capture_i` is high and `dbg_force_i` is low, the register takes the following layout, readable from the next cycle:
  - bit 7 = power-on detect
  - bit 6 = external reset pin low
  - bit 5 = watchdog timeout
  - bit 4 = illegal opcode
  - bit 3 = illegal address
  - bit 1 = low-voltage detect
- R3: A capture with power-on detect high sets bit 1 as well as bit 7, even when the low-voltage input is low. A power-on capture with no other source gives 0x82.
- R4: A capture with `dbg_force_i` high clears all eight bits, whatever the other sources are.
- R5: Each clock edge with `bus_sel_i`, `bus_wr_i` and `bus_addr_i == REG_ADDR` gives `wdog_clr_o` high for exactly the following cycle. Writes to other addresses, and reads, leave it low.
- R6: A bus write to any address does not change the register.
- R7: Bits 2 and 0 always read 0.
- R8: Bit 6 is set only when `ext_rst_n_i` is low at capture. A high pin level clears it.
- R9: Between captures the register holds its value.
- R10: `bus_rdata_o` shows the register when `bus_sel_i` is high, `bus_wr_i` is low and the address matches. In every other case it shows 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| capture_i | input | 1 | Reset-entry strobe from the sequencer |
| por_i | input | 1 | Power-on detect |
| lvd_i | input | 1 | Low-voltage detect |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdog_to_i | input | 1 | Watchdog timeout |
| ill_op_i | input | 1 | Illegal opcode event |
| ill_addr_i | input | 1 | Illegal address event |
| dbg_force_i | input | 1 | Debug-host forced reset |
| bus_sel_i | input | 1 | Bus access valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_rdata_o | output | 8 | Read data |
| wdog_clr_o | output | 1 | Watchdog-clear pulse |

## Verification
The bench aims at the following corner cases, each with the failure it would catch:
- **Power-on capture with the low-voltage input low.** A design that copied the inputs one to one would read 0x80 instead of 0x82.
- **Debug-forced capture with every other source active.** A design with the wrong priority would report stale or mixed flags.
- **Writes landing on capture-free cycles.** A design that let the bus write the register would lose the flags.
- **Back-to-back writes, and writes to neighbouring addresses.** A wrong address compare, or a pulse stretched across writes, would show up as extra or missing watchdog-clear pulses.
- **Random source mixes.** These include the reset pin held high, so an inverted pin polarity would be exposed.

// File: rtl/rst_cause_latch.sv
module rst_cause_latch #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              por_i,
  input  logic              lvd_i,
  input  logic              ext_rst_n_i,
  input  logic              wdog_to_i,
  input  logic              ill_op_i,
  input  logic              ill_addr_i,
  input  logic              dbg_force_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [7:0]        bus_rdata_o,
  output logic              wdog_clr_o
);

  logic [7:0] flags;
  logic [7:0] snap;
  logic       hit;
  logic       clr_q;

  assign hit = bus_sel_i && (bus_addr_i == REG_ADDR);

  // power-on implies low-voltage: supply is below threshold while ramping
  assign snap = dbg_force_i ? 8'h00 :
                {por_i, ~ext_rst_n_i, wdog_to_i, ill_op_i, ill_addr_i,
                 1'b0, por_i | lvd_i, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= 8'h00;
    else if (capture_i) flags <= snap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= hit && bus_wr_i;
  end

  assign wdog_clr_o  = clr_q;
  assign bus_rdata_o = (hit && !bus_wr_i) ? flags : 8'h00;

endmodule

// File: rtl/rst_cause_latch_chk.sv
module rst_cause_latch_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              capture_i,
  input logic              por_i,
  input logic              ext_rst_n_i,
  input logic              dbg_force_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        flags,
  input logic              wdog_clr_o
);

  a_r3_por_sets_lvd: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && por_i && !dbg_force_i |=> flags[7] && flags[1]);

  a_r4_debug_clears: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && dbg_force_i |=> flags == 8'h00);

  a_r5_pulse_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_i && bus_wr_i && bus_addr_i == REG_ADDR |=> wdog_clr_o);

  a_r5_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel_i && bus_wr_i && bus_addr_i == REG_ADDR) |=> !wdog_clr_o);

  a_r6_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(flags));

  a_r8_pin_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && ext_rst_n_i |=> !flags[6]);

endmodule

bind rst_cause_latch rst_cause_latch_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .capture_i(capture_i), .por_i(por_i),
  .ext_rst_n_i(ext_rst_n_i), .dbg_force_i(dbg_force_i), .bus_sel_i(bus_sel_i),
  .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .flags(flags),
  .wdog_clr_o(wdog_clr_o)
);

// File: tb/tb_rst_cause_latch.sv
`timescale 1ns/1ps
module tb_rst_cause_latch;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] RA = 8'h00;

  logic clk = 0, rst_n = 0;
  logic capture_i = 0, por_i = 0, lvd_i = 0, ext_rst_n_i = 1, wdog_to_i = 0;
  logic ill_op_i = 0, ill_addr_i = 0, dbg_force_i = 0;
  logic bus_sel_i = 0, bus_wr_i = 0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [7:0] bus_rdata_o;
  logic wdog_clr_o;

  int tests = 0, fails = 0;
  logic [7:0] model = 8'h00;
  bit exp_clr = 0;
  bit done = 0;

  rst_cause_latch #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) dut (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] expect_snap(bit por, bit lvd, bit pin_n, bit wd,
                                             bit op, bit ad, bit dbg);
    if (dbg) return 8'h00;
    return {por, !pin_n, wd, op, ad, 1'b0, por | lvd, 1'b0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, check pulse and register after the edge
  task automatic step(bit cap, bit por, bit lvd, bit pin_n, bit wd, bit op,
                      bit ad, bit dbg, bit sel, bit wr, logic [7:0] addr, string req);
    @(negedge clk);
    capture_i = cap; por_i = por; lvd_i = lvd; ext_rst_n_i = pin_n;
    wdog_to_i = wd; ill_op_i = op; ill_addr_i = ad; dbg_force_i = dbg;
    bus_sel_i = sel; bus_wr_i = wr; bus_addr_i = addr;
    #0.5;
    if (sel && wr) chk("R10", bus_rdata_o, 8'h00);
    else if (sel && !wr && addr != RA) chk("R10", bus_rdata_o, 8'h00);
    @(posedge clk);
    if (cap) model = expect_snap(por, lvd, pin_n, wd, op, ad, dbg);
    exp_clr = sel && wr && (addr == RA);
    #1;
    chk({req, "/R5"}, {7'd0, wdog_clr_o}, {7'd0, exp_clr});
    capture_i = 0; bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = RA;
    #0.5;
    chk({req, "/R9"}, bus_rdata_o, model);
    chk("R7", bus_rdata_o & 8'h05, 8'h00);
  endtask

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    bus_sel_i = 1; bus_addr_i = RA;
    #0.5;
    chk("R1", bus_rdata_o, 8'h00);
    chk("R1", {7'd0, wdog_clr_o}, 8'h00);
    bus_sel_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    step(1,1,0,1,0,0,0,0, 0,0,8'h00, "R3");
    chk("R3", model, 8'h82);
    step(0,0,0,1,0,0,0,0, 1,1,RA, "R6");
    step(0,0,0,1,0,0,0,0, 1,1,RA, "R5");
    step(0,0,0,1,0,0,0,0, 1,1,8'h01, "R5");
    step(1,1,1,0,1,1,1,1, 1,1,RA, "R4");
    chk("R4", model, 8'h00);
    step(1,0,0,0,0,0,0,0, 0,0,8'h00, "R8");
    chk("R8", model, 8'h40);
    step(1,0,0,1,1,0,1,0, 0,0,8'h00, "R2");
    chk("R2", model, 8'h28);
    step(1,0,1,1,0,1,0,0, 1,0,8'h02, "R2");
    chk("R2", model, 8'h12);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] r = 8'($urandom);
      logic [7:0] s = 8'($urandom);
      logic [7:0] a = ($urandom % 4 == 0) ? 8'($urandom) : RA;
      step(($urandom % 4) == 0, s[0], s[1], s[2], s[3], s[4], s[5],
           ($urandom % 8) == 0, r[0] | r[1], r[2], a, "R2");
    end

    @(negedge clk) rst_n = 0;
    #0.5;
    chk("R1", bus_rdata_o, 8'h00);
    chk("R1", {7'd0, wdog_clr_o}, 8'h00);
    finish_run();
  end
endmodule